// File: doc/BRIEF.md
# Block-Transfer Serial Control Register Bank

This block is a two-wire serial bus slave that holds nine 8-bit control registers for a clock generator. It has no register pointer. Every connection starts at register 0. In a write, the master sends two header bytes (a command byte and a length byte). The slave acknowledges both and then drops them. Each data byte after the header goes to the next register, counting up from register 0. In a read, the slave first sends a length byte of 9, then sends the registers from register 0 upward, and pads with 0xFF once the registers run out.

The bus pins are oversampled on a fast system clock through two-flop synchronizers, so the block sees SCL and SDA as ordinary synchronous inputs. The slave drives SDA only low, through an open-drain enable. Five strap inputs hold values that were latched at power-up. Some register bits read back as the inverse of these straps, and writes to those bits have no effect. The full register contents, with these read-only bits applied, appear on one flat output bus.

Top module: `i2c_blk_regbank`

## Requirements
- R1: After reset the register bytes read as follows. Byte 0 = 0x02, byte 4 = 0x00, byte 8 = 0x03, and bytes 2, 6 and 7 = 0xFF. Bytes 1, 3 and 5 hold 1 on every writable bit. Byte i sits on regs_o[8*i+7:8*i].
- R2: The slave acknowledges an address byte only when its upper seven bits are 1101001. That is 0xD2 for a write and 0xD3 for a read, with bit 0 as the direction (1 = read). After any other address, the slave leaves SDA released until the next START.
- R3: In a write, the first two bytes after the address are discarded. The next bytes land in registers 0, 1, 2 and upward. Any bytes beyond the ninth data byte are dropped, and no register changes outside a write.
- R4: The slave acknowledges every byte it receives after a matching address by holding SDA low for the ninth SCL pulse. The slave changes SDA only while SCL is low.
- R5: Some register bits are read-only and always show an inverted strap value:
  - byte 1 bit 7 = ~strap[2]
  - byte 1 bit 6 = ~strap[1]
  - byte 1 bit 4 = ~strap[0]
  - byte 3 bit 7 = ~strap[3]
  - byte 5 bit 7 = ~strap[4]

  Writes to these bits have no effect.
- R6: In a read, the first byte the slave sends is 9. Every byte is sent most significant bit first.
- R7: In a read, the length byte is followed by registers 0 to 8 in order, each equal to its value on regs_o.
- R8: After register 8, the slave sends 0xFF. When the master answers a byte with NACK, the slave releases SDA and ignores the bus until the next START.
- R9: A STOP, or a repeated START, at any point returns the slave to address reception. The next transfer again begins at register 0.
- R10: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Bytes clocked without a preceding START are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap | input | 5 | Power-up latched strap values |
| sda_oe | output | 1 | 1 pulls SDA low |
| regs_o | output | 8*NREG | Register contents with read-only bits applied, byte 0 lowest |

## Verification
Two things can happen on the same SCL falling edge. In a write, the edge that ends a data byte both commits the register write and raises the acknowledge. In a read, the edge that ends an acknowledge both loads the next byte and drives its first bit. The bench provokes both with back-to-back bytes, with no idle time between them. It also sends a repeated START directly after a committed write and then reads register 0 inside the same connection. These cases are judged against a behavioural model of the register contents, which is compared on every clock while the bus is quiet, and against the bits sampled from the bus.

// File: rtl/i2c_blk_regbank.sv
module i2c_blk_regbank #(
  parameter int NREG = 9,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] CNT_BYTE = 8'd9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [4:0]        strap,
  output logic              sda_oe,
  output logic [8*NREG-1:0] regs_o
);

  localparam int CW = $clog2(NREG + 3) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  function automatic logic [8*NREG-1:0] mk_rst();
    logic [8*NREG-1:0] v;
    for (int i = 0; i < NREG; i++) begin
      case (i)
        0: v[8*i +: 8] = 8'h02;
        4: v[8*i +: 8] = 8'h00;
        8: v[8*i +: 8] = 8'h03;
        default: v[8*i +: 8] = 8'hFF;
      endcase
    end
    return v;
  endfunction

  localparam logic [8*NREG-1:0] RST_VAL = mk_rst();

  typedef enum logic [2:0] {IDLE, ADDR, ACK, RX, TX, TXACK} st_t;

  st_t st;
  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q, rw, nack;
  logic [3:0] bitc;
  logic [7:0] sh, txb;
  logic [CW-1:0] bcnt;
  logic [8*NREG-1:0] raw;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det = scl_s & scl_q & ~sda_q & sda_s;
  wire [CW-1:0] widx = bcnt - CW'(2);
  wire [CW-1:0] ridx = bcnt - CW'(1);

  for (genvar g = 0; g < NREG; g++) begin : g_view
    if (g == 1) begin : g_b1
      assign regs_o[8*g +: 8] = {~strap[2], ~strap[1], raw[8*g+5], ~strap[0], raw[8*g +: 4]};
    end else if (g == 3) begin : g_b3
      assign regs_o[8*g +: 8] = {~strap[3], raw[8*g +: 7]};
    end else if (g == 5) begin : g_b5
      assign regs_o[8*g +: 8] = {~strap[4], raw[8*g +: 7]};
    end else begin : g_rw
      assign regs_o[8*g +: 8] = raw[8*g +: 8];
    end
  end

  always_comb begin
    if (bcnt == '0) txb = CNT_BYTE;
    else if (bcnt <= CW'(NREG)) txb = regs_o[8*ridx +: 8];
    else txb = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      st     <= IDLE;
      sda_oe <= 1'b0;
      rw     <= 1'b0;
      nack   <= 1'b0;
      bitc   <= '0;
      sh     <= '0;
      bcnt   <= '0;
      raw    <= RST_VAL;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      if (start_det) begin
        st     <= ADDR;
        bitc   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ADDR, RX: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_s};
              bitc <= bitc + 4'd1;
            end else if (scl_fall && bitc == 4'd8) begin
              if (st == ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw     <= sh[0];
                  bcnt   <= '0;
                  sda_oe <= 1'b1;
                  st     <= ACK;
                end else begin
                  st <= IDLE;
                end
              end else begin
                if (bcnt >= CW'(2) && bcnt < CW'(NREG + 2)) raw[8*widx +: 8] <= sh;
                if (bcnt != CMAX) bcnt <= bcnt + CW'(1);
                sda_oe <= 1'b1;
                st     <= ACK;
              end
            end
          end
          ACK: begin
            if (scl_fall) begin
              bitc <= '0;
              if (rw) begin
                sh     <= txb;
                sda_oe <= ~txb[7];
                st     <= TX;
                if (bcnt != CMAX) bcnt <= bcnt + CW'(1);
              end else begin
                sda_oe <= 1'b0;
                st     <= RX;
              end
            end
          end
          TX: begin
            if (scl_fall) begin
              if (bitc == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= TXACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
                bitc   <= bitc + 4'd1;
              end
            end
          end
          TXACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                st <= IDLE;
              end else begin
                sh     <= txb;
                sda_oe <= ~txb[7];
                bitc   <= '0;
                st     <= TX;
                if (bcnt != CMAX) bcnt <= bcnt + CW'(1);
              end
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

endmodule

module i2c_blk_regbank_chk #(
  parameter int NREG = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic [2:0]        st,
  input logic              sda_oe,
  input logic [4:0]        strap,
  input logic [8*NREG-1:0] regs_o
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe); // R2

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s)); // R4

  AST_RO_BYTE1: assert property (@(posedge clk) disable iff (!rst_n)
    {regs_o[15], regs_o[14], regs_o[12]} == ~{strap[2], strap[1], strap[0]}); // R5

  AST_RO_BYTE3_5: assert property (@(posedge clk) disable iff (!rst_n)
    {regs_o[31], regs_o[47]} == ~{strap[3], strap[4]}); // R5

  AST_IDLE_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |=> ($stable(regs_o) || !$stable(strap))); // R3

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == 3'd1)); // R9

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == 3'd0)); // R10

endmodule

bind i2c_blk_regbank i2c_blk_regbank_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .st(st), .sda_oe(sda_oe), .strap(strap), .regs_o(regs_o)
);

// File: tb/sim_i2c_blk_regbank.sv
module sim_i2c_blk_regbank;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic [4:0] strap = 5'b10110;
  logic sda_oe;
  logic [71:0] regs_o;
  logic sda_line;
  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  logic cmp_en = 1'b0;
  logic done = 1'b0;
  logic [7:0] mraw [9];

  assign sda_line = !(m_low || sda_oe);

  always #4 clk = ~clk;

  i2c_blk_regbank u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap(strap), .sda_oe(sda_oe), .regs_o(regs_o)
  );

  function automatic logic [7:0] view(int i);
    logic [7:0] r = mraw[i];
    if (i == 1) return {~strap[2], ~strap[1], r[5], ~strap[0], r[3:0]};
    if (i == 3) return {~strap[3], r[6:0]};
    if (i == 5) return {~strap[4], r[6:0]};
    return r;
  endfunction

  function automatic logic [71:0] view_all();
    logic [71:0] v;
    for (int i = 0; i < 9; i++) v[8*i +: 8] = view(i);
    return v;
  endfunction

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      nchk++;
      if (regs_o !== view_all()) begin
        nerr++;
        $display("FAIL R3 model compare: actual %h expected %h", regs_o, view_all());
      end
    end
  end

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; waitq();
    scl = 1'b1; waitq();
    m_low = 1'b1; waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; waitq();
    scl = 1'b1; waitq();
    m_low = 1'b0; waitq();
  endtask

  task automatic wbit(logic b);
    m_low = ~b; waitq();
    scl = 1'b1; waitq(); waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic rbit(output logic b);
    m_low = 1'b0; waitq();
    scl = 1'b1; waitq();
    b = sda_line; waitq();
    scl = 1'b0; waitq();
  endtask

  task automatic send(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic recv(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(~ack);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      nerr = nerr + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic [7:0] wd [11];
    wd = '{8'hA5, 8'h00, 8'h3C, 8'h00, 8'h81, 8'h00, 8'h5A, 8'hC3, 8'h7E, 8'h99, 8'h66};
    for (int i = 0; i < 9; i++) mraw[i] = 8'hFF;
    mraw[0] = 8'h02; mraw[4] = 8'h00; mraw[8] = 8'h03;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state, R5 strap overlay
    check8("R1 byte0", regs_o[7:0], 8'h02);
    check8("R1 byte2", regs_o[23:16], 8'hFF);
    check8("R1 byte4", regs_o[39:32], 8'h00);
    check8("R1 byte8", regs_o[71:64], 8'h03);
    check8("R5 byte1", regs_o[15:8], 8'h3F);
    check8("R5 byte5", regs_o[47:40], 8'h7F);
    check8("R1 sda released", {7'd0, sda_oe}, 8'h00);
    cmp_en = 1'b1;

    // R2 foreign address ignored
    bus_start();
    send(8'hA0, ack);
    check8("R2 foreign address nack", {7'd0, ack}, 8'h00);
    send(8'h00, ack);
    check8("R2 no ack after foreign address", {7'd0, ack}, 8'h00);
    bus_stop();

    // R10 bytes without START are ignored
    bus_start();
    wbit(1'b1); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    bus_stop();
    send(8'hD2, ack);
    check8("R10 no START no ack", {7'd0, ack}, 8'h00);
    bus_stop();

    // R3 R4 write with header and overflow bytes
    cmp_en = 1'b0;
    bus_start();
    send(8'hD2, ack);
    check8("R2 write address ack", {7'd0, ack}, 8'h01);
    send(8'h55, ack);
    check8("R4 command ack", {7'd0, ack}, 8'h01);
    send(8'h07, ack);
    check8("R4 count ack", {7'd0, ack}, 8'h01);
    for (int i = 0; i < 11; i++) begin
      send(wd[i], ack);
      check8("R4 data ack", {7'd0, ack}, 8'h01);
    end
    bus_stop();
    for (int i = 0; i < 9; i++) mraw[i] = wd[i];
    repeat (5) @(negedge clk);
    cmp_en = 1'b1;
    check8("R3 byte0 from first data", regs_o[7:0], 8'hA5);
    check8("R3 byte8 excess dropped", regs_o[71:64], 8'h7E);
    check8("R5 byte1 ro bits", regs_o[15:8], 8'h10);
    check8("R5 byte3 ro bit", regs_o[31:24], 8'h80);

    // R6 R7 R8 read
    bus_start();
    send(8'hD3, ack);
    check8("R2 read address ack", {7'd0, ack}, 8'h01);
    recv(d, 1'b1);
    check8("R6 count byte", d, 8'd9);
    for (int i = 0; i < 9; i++) begin
      recv(d, 1'b1);
      check8("R7 register byte", d, view(i));
    end
    recv(d, 1'b1);
    check8("R8 pad byte", d, 8'hFF);
    recv(d, 1'b0);
    check8("R8 pad byte last", d, 8'hFF);
    repeat (10) @(negedge clk);
    check8("R8 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();

    // R9 repeated START after committed write
    cmp_en = 1'b0;
    bus_start();
    send(8'hD2, ack);
    send(8'h00, ack);
    send(8'h01, ack);
    send(8'h11, ack);
    mraw[0] = 8'h11;
    bus_start();
    send(8'hD3, ack);
    check8("R9 repeated start address ack", {7'd0, ack}, 8'h01);
    recv(d, 1'b1);
    check8("R9 count after restart", d, 8'd9);
    recv(d, 1'b0);
    check8("R9 byte0 after restart", d, 8'h11);
    bus_stop();
    repeat (5) @(negedge clk);
    cmp_en = 1'b1;

    // R9 STOP mid-header, next transfer restarts at byte 0
    cmp_en = 1'b0;
    bus_start();
    send(8'hD2, ack);
    send(8'h00, ack);
    bus_stop();
    bus_start();
    send(8'hD2, ack);
    send(8'h00, ack);
    send(8'h02, ack);
    send(8'h44, ack);
    send(8'h55, ack);
    bus_stop();
    mraw[0] = 8'h44; mraw[1] = 8'h55;
    repeat (5) @(negedge clk);
    cmp_en = 1'b1;
    check8("R9 byte0 restart", regs_o[7:0], 8'h44);
    check8("R9 byte1 restart", regs_o[15:8], 8'h15);
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule